// File: doc/BRIEF.md
# Utility Port Register with Mode-Dependent Pin Drive

This block is one 8-bit utility register that a host reaches over a control port, together with the logic that decides how the register meets a shared 8-bit data pin bus. Its fields serve three purposes:
- two upper bits report live input pins;
- four middle bits are read/write storage that drives pins;
- two low bits are read-only live status flags from the video timing core: the colour burst window and the composite sync level.

The mode select input decides how the register reaches the pins. In serial control mode the pins are permanently split: the two top pins are inputs, the storage bits drive their four pins at all times, and the two flag pins follow the timing core whatever the control port is doing. In parallel control mode the bus belongs to the control port. The register drives all eight pins only while a read of its address is in progress, so a host that reads back to back gets a continuous copy of storage and flags on the pins.

The access interface is a single strobe with a write qualifier, an address and write data. A write lands on the rising clock edge. Read data is combinational and valid while the read strobe is held. The serial protocol engine and the timing core sit outside this block.

Top module: `gpio_util_port`

## Requirements
- R1: Synchronous active-low reset clears the four storage bits (register bits 5..2) to 0.
- R2: A write strobe (`acc_sel`=1, `acc_wr`=1) to address 0x0E copies `acc_wdata[5:2]` into the storage on the clock edge. Any later read of 0x0E returns those values in bits 5..2.
- R3: Written values in bits 7, 6, 1 and 0 are discarded. Reads of those bits always show the live sources, never written data.
- R4: In serial mode (`ser_mode`=1), a read of 0x0E returns `pin_in[7:6]` in bits 7..6, sampled at the moment of the read.
- R5: In parallel mode (`ser_mode`=0), a read of 0x0E returns 0 in bits 7..6.
- R6: In serial mode, `pin_oe[7:6]`=0 and `pin_oe[5:2]`=1 continuously. `pin_out[5:2]` equals the storage, with 1 driving high and 0 driving low.
- R7: In serial mode, `pin_oe[1:0]`=1 at all times, `pin_out[1]` follows `burst_flag` and `pin_out[0]` follows `csync_n`, regardless of control port activity.
- R8: In parallel mode, when no read of 0x0E is in progress, `pin_oe` is 0x00 and `pin_out` is 0x00.
- R9: In parallel mode, during a read of 0x0E, `pin_oe` is 0xFF and `pin_out` equals the read word. The flag bits follow their inputs live within the read.
- R10: Read bit 1 is `burst_flag` and read bit 0 is `csync_n` (low during sync tips), live in both modes.
- R11: Accesses to any address other than 0x0E leave the storage unchanged and return 0.
- R12: `acc_rdata` is 0x00 whenever no read of 0x0E is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_mode | input | 1 | 1 = serial control mode, 0 = parallel control mode |
| acc_sel | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read, qualified by `acc_sel` |
| acc_addr | input | 4 | Register address of the access |
| acc_wdata | input | 8 | Write data |
| pin_in | input | 8 | Levels present on the data pins |
| burst_flag | input | 1 | Colour burst window from the timing core, high around the burst |
| csync_n | input | 1 | Composite sync from the timing core, low during sync tips |
| acc_rdata | output | 8 | Read data, valid while a read of 0x0E is held |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
The assertions assume that the access strobe, write qualifier and address are settled around each rising clock edge. They also assume that mode changes happen between accesses, not within one.

The stimulus follows these assumptions:
- it changes every control input half a cycle away from the active edge;
- it holds a strobe for a whole cycle;
- it switches `ser_mode` only on an idle cycle or at a vector boundary.

The single exception is the flag input: it is deliberately moved in the middle of a held read, because the flags are meant to be live.

// File: rtl/gup_pkg.sv
// Package: gup_pkg
// Shared constants for the utility port register: field positions on the
// data bus (these are behavioural, the pin wiring depends on them) and the
// pin classification used by the pin driver.
package gup_pkg;

    localparam int DATA_W    = 8;
    localparam int GPI_HI    = 7;
    localparam int GPI_LO    = 6;
    localparam int GPO_HI    = 5;
    localparam int GPO_LO    = 2;
    localparam int BURST_BIT = 1;
    localparam int SYNC_BIT  = 0;
    localparam int GPI_W     = GPI_HI - GPI_LO + 1;
    localparam int GPO_W     = GPO_HI - GPO_LO + 1;

    typedef enum logic [1:0] {
        PIN_IN   = 2'd0,
        PIN_OUT  = 2'd1,
        PIN_FLAG = 2'd2
    } pin_kind_e;

    // Classify a bus bit by the field it belongs to.
    function automatic pin_kind_e pin_kind(input int idx);
        if (idx >= GPI_LO) return PIN_IN;
        if (idx >= GPO_LO) return PIN_OUT;
        return PIN_FLAG;
    endfunction

endpackage

// File: rtl/gup_decode.sv
// Module: gup_decode
// Turns the access strobe into write-hit and read-hit for one register
// address. Assumes strobe, direction and address are stable around the edge.
module gup_decode #(
    parameter int              ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'hE
) (
    input  logic              acc_sel,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              wr_hit,
    output logic              rd_hit
);

    logic addr_match;

    // Address compare and direction split.
    always_comb begin
        addr_match = (acc_addr == REG_ADDR);
        wr_hit     = acc_sel &  acc_wr & addr_match;
        rd_hit     = acc_sel & ~acc_wr & addr_match;
    end

endmodule

// File: rtl/gup_store.sv
// Module: gup_store
// Read/write storage field, loaded on a write hit, cleared by synchronous
// active-low reset. Holds its value on every other cycle.
module gup_store #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Storage update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= d;
    end

endmodule

// File: rtl/gup_pin_drive.sv
// Module: gup_pin_drive
// Per-pin output enable and value. Serial mode: input pins released, storage
// and flag pins always driven from the live word. Parallel mode: the whole bus
// carries the read word only while a read hit is active.
module gup_pin_drive
    import gup_pkg::*;
(
    input  logic              ser_mode,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] live_word,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] pin_out
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_pin
        localparam pin_kind_e KIND = pin_kind(i);
        if (KIND == PIN_IN) begin : g_in
            // Input pins: released in serial mode, read copy in parallel mode.
            always_comb begin
                pin_oe[i]  = ~ser_mode & rd_hit;
                pin_out[i] = (~ser_mode & rd_hit) ? rd_word[i] : 1'b0;
            end
        end else begin : g_drv
            // Storage and flag pins: always driven in serial mode.
            always_comb begin
                if (ser_mode) begin
                    pin_oe[i]  = 1'b1;
                    pin_out[i] = live_word[i];
                end else begin
                    pin_oe[i]  = rd_hit;
                    pin_out[i] = rd_hit ? rd_word[i] : 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/gpio_util_port.sv
// Module: gpio_util_port
// Utility port register at one control-port address: two live pin inputs,
// four stored outputs, two live status flags. Drives the shared pin bus
// according to control mode. Assumes status flags are synchronous to clk.
module gpio_util_port
    import gup_pkg::*;
#(
    parameter int              ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic              acc_sel,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] pin_in,
    input  logic              burst_flag,
    input  logic              csync_n,
    output logic [DATA_W-1:0] acc_rdata,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] pin_out
);

    logic             wr_hit;
    logic             rd_hit;
    logic [GPO_W-1:0] store_q;
    logic [GPI_W-1:0] gpi_val;
    logic [DATA_W-1:0] live_word;
    logic [DATA_W-1:0] rd_word;
    logic             unused_bits;

    gup_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .acc_sel (acc_sel),
        .acc_wr  (acc_wr),
        .acc_addr(acc_addr),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit)
    );

    gup_store #(.W(GPO_W)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_hit),
        .d    (acc_wdata[GPO_HI:GPO_LO]),
        .q    (store_q)
    );

    // Assemble live and read words from pins, storage and flags.
    always_comb begin
        gpi_val   = ser_mode ? pin_in[GPI_HI:GPI_LO] : '0;
        live_word = '0;
        live_word[GPO_HI:GPO_LO] = store_q;
        live_word[BURST_BIT]     = burst_flag;
        live_word[SYNC_BIT]      = csync_n;
        rd_word   = live_word;
        rd_word[GPI_HI:GPI_LO]   = gpi_val;
        acc_rdata = rd_hit ? rd_word : '0;
    end

    // Bits that carry no function here, folded so nothing is left dangling.
    assign unused_bits = ^{pin_in[GPO_HI:0], acc_wdata[GPI_HI:GPI_LO],
                           acc_wdata[BURST_BIT:SYNC_BIT]};

    gup_pin_drive u_drv (
        .ser_mode (ser_mode),
        .rd_hit   (rd_hit),
        .live_word(live_word),
        .rd_word  (rd_word),
        .pin_oe   (pin_oe),
        .pin_out  (pin_out)
    );

endmodule

// File: rtl/gpio_util_port_chk.sv
// Module: gpio_util_port_chk
// Property checker for gpio_util_port, attached by bind. Assumes access
// controls are settled at each rising edge.
module gpio_util_port_chk
    import gup_pkg::*;
#(
    parameter int              ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'hE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_mode,
    input logic              acc_sel,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] pin_in,
    input logic              burst_flag,
    input logic              csync_n,
    input logic [DATA_W-1:0] acc_rdata,
    input logic [DATA_W-1:0] pin_oe,
    input logic [DATA_W-1:0] pin_out,
    input logic [GPO_W-1:0]  stored
);

    logic wr_on, rd_on;
    assign wr_on = acc_sel &  acc_wr & (acc_addr == REG_ADDR);
    assign rd_on = acc_sel & ~acc_wr & (acc_addr == REG_ADDR);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> stored == '0);

    assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_on |=> stored == $past(acc_wdata[GPO_HI:GPO_LO]));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_on |=> $stable(stored));

    assert_gpi_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && rd_on) |-> acc_rdata[GPI_HI:GPI_LO] == pin_in[GPI_HI:GPI_LO]);

    assert_serial_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_mode |-> (pin_oe == 8'h3F && pin_out[GPO_HI:GPO_LO] == stored));

    assert_flag_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_mode |-> (pin_out[BURST_BIT] == burst_flag && pin_out[SYNC_BIT] == csync_n));

    assert_par_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && !rd_on) |-> (pin_oe == '0 && pin_out == '0));

    assert_par_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && rd_on) |-> (pin_oe == 8'hFF && pin_out == acc_rdata));

    assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_on |-> acc_rdata == '0);

endmodule

bind gpio_util_port gpio_util_port_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_mode  (ser_mode),
    .acc_sel   (acc_sel),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .pin_in    (pin_in),
    .burst_flag(burst_flag),
    .csync_n   (csync_n),
    .acc_rdata (acc_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .stored    (store_q)
);

// File: tb/sim_gpio_util_port.sv
// Bench for gpio_util_port: vector table walk, then directed reset and
// mid-read tests. Inputs change on the falling edge, checks sit 5 ns later.
module sim_gpio_util_port;

    typedef struct packed {
        logic       ser;
        logic       sel;
        logic       wr;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic [7:0] pins;
        logic       burst;
        logic       sync;
        logic [7:0] exp_rd;
        logic [7:0] exp_oe;
        logic [7:0] exp_out;
    } vec_t;

    localparam int NV = 13;
    // Expected values reflect storage before the edge that ends each vector.
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b0,4'hE,8'h00,8'hC0,1'b0,1'b1,8'h00,8'h3F,8'h01}, // R6 R7 R12 idle serial
        '{1'b1,1'b1,1'b1,4'hE,8'hFF,8'h00,1'b1,1'b1,8'h00,8'h3F,8'h03}, // R2 write all ones
        '{1'b1,1'b1,1'b0,4'hE,8'h00,8'h80,1'b0,1'b0,8'hBC,8'h3F,8'h3C}, // R2 R3 R4 R10 readback
        '{1'b1,1'b1,1'b1,4'h5,8'h00,8'h40,1'b1,1'b0,8'h00,8'h3F,8'h3E}, // R11 foreign write
        '{1'b1,1'b1,1'b0,4'h5,8'h00,8'h00,1'b0,1'b1,8'h00,8'h3F,8'h3D}, // R11 foreign read
        '{1'b0,1'b0,1'b0,4'hE,8'h00,8'hFF,1'b1,1'b1,8'h00,8'h00,8'h00}, // R8 parallel idle
        '{1'b0,1'b1,1'b0,4'hE,8'h00,8'hC0,1'b1,1'b0,8'h3E,8'hFF,8'h3E}, // R5 R9 R10 parallel read
        '{1'b0,1'b1,1'b1,4'hE,8'h94,8'h00,1'b0,1'b1,8'h00,8'h00,8'h00}, // R2 R8 parallel write
        '{1'b0,1'b1,1'b0,4'hE,8'h00,8'hFF,1'b0,1'b1,8'h15,8'hFF,8'h15}, // R2 R5 R9 reread
        '{1'b0,1'b1,1'b0,4'hF,8'h00,8'h00,1'b1,1'b1,8'h00,8'h00,8'h00}, // R11 R8 other address
        '{1'b1,1'b1,1'b0,4'hE,8'h00,8'h40,1'b1,1'b1,8'h57,8'h3F,8'h17}, // R4 R6 R7 serial read
        '{1'b1,1'b1,1'b1,4'hE,8'h03,8'hC0,1'b0,1'b0,8'h00,8'h3F,8'h14}, // R2 R3 clear write
        '{1'b1,1'b0,1'b0,4'hE,8'h00,8'h00,1'b0,1'b1,8'h00,8'h3F,8'h01}  // R2 R6 cleared storage
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_mode = 1'b1;
    logic       acc_sel = 1'b0;
    logic       acc_wr = 1'b0;
    logic [3:0] acc_addr = 4'h0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] pin_in = 8'h00;
    logic       burst_flag = 1'b0;
    logic       csync_n = 1'b1;
    logic [7:0] acc_rdata, pin_oe, pin_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_util_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .acc_sel(acc_sel),
        .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .pin_in(pin_in), .burst_flag(burst_flag), .csync_n(csync_n),
        .acc_rdata(acc_rdata), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    initial begin
        #200_000_0;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        // Reset state, serial idle.
        chk("R1 reset pin_out", pin_out, 8'h01);
        chk("R6 reset pin_oe", pin_oe, 8'h3F);
        chk("R12 reset rdata", acc_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ser_mode   = TBL[i].ser;
            acc_sel    = TBL[i].sel;
            acc_wr     = TBL[i].wr;
            acc_addr   = TBL[i].addr;
            acc_wdata  = TBL[i].wdata;
            pin_in     = TBL[i].pins;
            burst_flag = TBL[i].burst;
            csync_n    = TBL[i].sync;
            #5;
            chk($sformatf("R2 R4 R5 R10 R11 R12 rdata vec%0d", i), acc_rdata, TBL[i].exp_rd);
            chk($sformatf("R6 R8 R9 pin_oe vec%0d", i), pin_oe, TBL[i].exp_oe);
            chk($sformatf("R6 R7 R9 pin_out vec%0d", i), pin_out, TBL[i].exp_out);
        end

        // Flags move inside a held parallel read (R9, R10).
        @(negedge clk);
        ser_mode = 1'b0; acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = 4'hE;
        burst_flag = 1'b0; csync_n = 1'b1;
        #3;
        chk("R9 in-read before", pin_out, 8'h01);
        burst_flag = 1'b1; csync_n = 1'b0;
        #2;
        chk("R9 in-read after", pin_out, 8'h02);
        chk("R10 in-read rdata", acc_rdata, 8'h02);

        // Serial flag pins ignore port activity (R7).
        @(negedge clk);
        ser_mode = 1'b1; acc_sel = 1'b1; acc_wr = 1'b1; acc_addr = 4'hE;
        acc_wdata = 8'h3C; burst_flag = 1'b1; csync_n = 1'b1;
        #5;
        chk("R7 flags during write", pin_out, 8'h03);
        @(negedge clk);
        acc_sel = 1'b0;
        #5;
        chk("R2 serial storage", pin_out, 8'h3F);

        // Reset clears storage (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        burst_flag = 1'b0;
        #5;
        chk("R1 cleared pins", pin_out, 8'h01);
        @(negedge clk);
        ser_mode = 1'b0; acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = 4'hE;
        #5;
        chk("R1 cleared readback", acc_rdata, 8'h01);

        @(negedge clk);
        acc_sel = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule